// File: doc/BRIEF.md
# Shared-Clock Wait-State Mailbox Between Two Processors

This block couples the data buses of a master and a slave processor through one bidirectional transceiver. Nothing in the block stores data. A processor that reads the mailbox is stalled by its wait line until the other processor writes to it. During that write the transceiver opens in the writer-to-reader direction, and the reader's wait is released in the same cycle, so the reader takes the data straight off the writer's bus. Both processors run from one shared clock, or from clocks no further apart than about two to one, because the data is only valid while the write strobe is active.

The master qualifies its accesses with a port select. The slave has no address decode. Any slave I/O request with its write strobe high counts as a mailbox read, and that includes an interrupt-acknowledge cycle. The master can therefore answer a slave interrupt acknowledge by writing a mode-2 vector. Writes are never stalled, so a reader must already be waiting when the write begins. A write that starts before the reader was waiting at a clock edge is dropped, and the reader keeps waiting for the next write. No valid/ready interface is used, because the block carries no data. Every pin is a plain control strobe, and the only back-pressure is the wait line.

Top module: `mbox_wait_bridge`

## Requirements
- R1: A master read (iorq_n low, rd_n low, wr_n high, sel high) drives m_wait_n low while no transfer to the master is open.
- R2: A slave read is any cycle with s_iorq_n low and s_wr_n high, with no address decode (interrupt acknowledge included). It drives s_wait_n low while no transfer to the slave is open.
- R3: A write never stalls: m_wait_n stays high during a master write, and s_wait_n stays high during a slave write.
- R4: If the reader was already reading at the previous rising clock edge, a write from the other side opens the transceiver (xcvr_oe_n low) in the same cycle. xcvr_dir is 1 for master-to-slave and 0 for slave-to-master, and the reader's wait goes high in that same cycle.
- R5: A write already active at the edge where the read was first seen, or one that starts in the same cycle as the read, is lost. The transceiver stays off and the reader keeps waiting until that write ends and a new write begins.
- R6: When both sides read at once, both wait lines are low and the transceiver is off.
- R7: xcvr_oe_n is low only while one side writes and the other side reads. Otherwise it is high.
- R8: With m_sel low, master strobes are ignored: the master is neither stalled nor treated as a writer.
- R9: While rst_n is low, both wait lines are high, the transceiver is off, and the arming state is cleared.
- R10: An open transfer stays open across clock edges for as long as the write and the read both continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both processors |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_iorq_n | input | 1 | Master I/O request, active low |
| m_rd_n | input | 1 | Master read strobe, active low |
| m_wr_n | input | 1 | Master write strobe, active low |
| m_sel | input | 1 | Master mailbox port select, active high |
| s_iorq_n | input | 1 | Slave I/O request, active low |
| s_wr_n | input | 1 | Slave write strobe, active low |
| m_wait_n | output | 1 | Master wait line, active low |
| s_wait_n | output | 1 | Slave wait line, active low |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = master to slave |

## Verification
The bench builds the block with its default REQUIRE_ARMED = 1. In that build the arming registers are present, so the bench can exercise the lost-write cases: a write that is already running when the read appears, and a write that starts in the same cycle as the read. It can also check that an open transfer survives clock edges. Held strobes of random length, on top of directed mutual-read, interrupt-acknowledge and deselected-master sequences, let each side reach every combination of read, write and idle against the other side's arming history.

// File: rtl/mbox_wait_pkg.sv
package mbox_wait_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } side_req_t;
endpackage

// File: rtl/mbox_side_decode.sv
module mbox_side_decode
  import mbox_wait_pkg::*;
#(
  parameter bit HAS_SELECT    = 1'b1,
  parameter bit HAS_RD_STROBE = 1'b1
) (
  input  logic      iorq_n,
  input  logic      rd_n,
  input  logic      wr_n,
  input  logic      sel,
  output side_req_t req
);
  logic sel_ok;
  logic rd_ok;

  assign sel_ok = HAS_SELECT    ? sel   : 1'b1;
  // Without a read strobe, any request with write high counts as a read
  assign rd_ok  = HAS_RD_STROBE ? !rd_n : 1'b1;

  always_comb begin
    req.rd = !iorq_n && wr_n && rd_ok && sel_ok;
    req.wr = !iorq_n && !wr_n && sel_ok;
  end
endmodule

// File: rtl/mbox_arm.sv
module mbox_arm #(
  parameter bit REQUIRE_ARMED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic peer_wr,
  output logic armed
);
  generate
    if (REQUIRE_ARMED) begin : g_reg
      logic armed_q;
      // Armed once the read is seen at an edge without a write already running;
      // stays armed for the rest of the read
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= rd && (armed_q || !peer_wr);
      end
      assign armed = armed_q;
    end else begin : g_comb
      assign armed = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/mbox_path_ctrl.sv
module mbox_path_ctrl
  import mbox_wait_pkg::*;
(
  input  logic      rst_n,
  input  side_req_t m_req,
  input  side_req_t s_req,
  input  logic      m_armed,
  input  logic      s_armed,
  output logic      m_wait_n,
  output logic      s_wait_n,
  output logic      xcvr_oe_n,
  output logic      xcvr_dir
);
  logic to_slave;
  logic to_master;

  assign to_slave  = s_req.rd && s_armed && m_req.wr;
  assign to_master = m_req.rd && m_armed && s_req.wr;

  assign m_wait_n  = !(rst_n && m_req.rd && !to_master);
  assign s_wait_n  = !(rst_n && s_req.rd && !to_slave);
  assign xcvr_oe_n = !(rst_n && (to_slave || to_master));
  assign xcvr_dir  = rst_n && to_slave;
endmodule

// File: rtl/mbox_wait_bridge.sv
module mbox_wait_bridge
  import mbox_wait_pkg::*;
#(
  parameter bit REQUIRE_ARMED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m_iorq_n,
  input  logic m_rd_n,
  input  logic m_wr_n,
  input  logic m_sel,
  input  logic s_iorq_n,
  input  logic s_wr_n,
  output logic m_wait_n,
  output logic s_wait_n,
  output logic xcvr_oe_n,
  output logic xcvr_dir
);
  side_req_t m_req;
  side_req_t s_req;
  logic      m_armed;
  logic      s_armed;

  mbox_side_decode #(.HAS_SELECT(1'b1), .HAS_RD_STROBE(1'b1)) u_m_dec (
    .iorq_n(m_iorq_n), .rd_n(m_rd_n), .wr_n(m_wr_n), .sel(m_sel), .req(m_req)
  );

  mbox_side_decode #(.HAS_SELECT(1'b0), .HAS_RD_STROBE(1'b0)) u_s_dec (
    .iorq_n(s_iorq_n), .rd_n(1'b1), .wr_n(s_wr_n), .sel(1'b1), .req(s_req)
  );

  mbox_arm #(.REQUIRE_ARMED(REQUIRE_ARMED)) u_m_arm (
    .clk(clk), .rst_n(rst_n), .rd(m_req.rd), .peer_wr(s_req.wr), .armed(m_armed)
  );

  mbox_arm #(.REQUIRE_ARMED(REQUIRE_ARMED)) u_s_arm (
    .clk(clk), .rst_n(rst_n), .rd(s_req.rd), .peer_wr(m_req.wr), .armed(s_armed)
  );

  mbox_path_ctrl u_ctrl (
    .rst_n(rst_n), .m_req(m_req), .s_req(s_req),
    .m_armed(m_armed), .s_armed(s_armed),
    .m_wait_n(m_wait_n), .s_wait_n(s_wait_n),
    .xcvr_oe_n(xcvr_oe_n), .xcvr_dir(xcvr_dir)
  );
endmodule

// File: rtl/mbox_wait_bridge_chk.sv
module mbox_wait_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic m_iorq_n,
  input logic m_rd_n,
  input logic m_wr_n,
  input logic m_sel,
  input logic s_iorq_n,
  input logic s_wr_n,
  input logic m_wait_n,
  input logic s_wait_n,
  input logic xcvr_oe_n,
  input logic xcvr_dir
);
  logic mr, mw, sr, sw;
  assign mr = !m_iorq_n && !m_rd_n && m_wr_n && m_sel;
  assign mw = !m_iorq_n && !m_wr_n && m_sel;
  assign sr = !s_iorq_n && s_wr_n;
  assign sw = !s_iorq_n && !s_wr_n;

  p_write_no_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mw |-> m_wait_n) and (sw |-> s_wait_n));

  p_oe_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_oe_n |-> ((mw && sr) || (sw && mr)));

  p_dir_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_oe_n |-> (m_wait_n && s_wait_n && (xcvr_dir == mw)));

  p_both_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mr && sr) |-> (!m_wait_n && !s_wait_n && xcvr_oe_n));

  p_lost_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && mw && $past(mw) && $past(xcvr_oe_n) && $past(rst_n)) |-> xcvr_oe_n);

  p_stay_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!xcvr_oe_n) && $past(mw) && mw && sr) |-> !xcvr_oe_n);

  p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !m_sel |-> (m_wait_n && (xcvr_oe_n || !xcvr_dir)));

  p_reset_safe_r9: assert property (@(posedge clk)
    !rst_n |-> (m_wait_n && s_wait_n && xcvr_oe_n));
endmodule

bind mbox_wait_bridge mbox_wait_bridge_chk u_chk (.*);

// File: tb/mbox_wait_bridge_tb_top.sv
module mbox_wait_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic m_iorq_n, m_rd_n, m_wr_n, m_sel, s_iorq_n, s_wr_n;
  logic m_wait_n, s_wait_n, xcvr_oe_n, xcvr_dir;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state
  int mop, sop;  // 0 idle, 1 read, 2 write, 3 slave iack
  bit msel_v;
  bit m_arm, s_arm;

  always #10 clk = ~clk;

  mbox_wait_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .m_iorq_n(m_iorq_n), .m_rd_n(m_rd_n), .m_wr_n(m_wr_n), .m_sel(m_sel),
    .s_iorq_n(s_iorq_n), .s_wr_n(s_wr_n),
    .m_wait_n(m_wait_n), .s_wait_n(s_wait_n),
    .xcvr_oe_n(xcvr_oe_n), .xcvr_dir(xcvr_dir)
  );

  function automatic bit f_mrd(int op, bit sel); return op == 1 && sel; endfunction
  function automatic bit f_mwr(int op, bit sel); return op == 2 && sel; endfunction
  function automatic bit f_srd(int op); return op == 1 || op == 3; endfunction
  function automatic bit f_swr(int op); return op == 2; endfunction

  // {m_wait_n, s_wait_n, xcvr_oe_n, xcvr_dir}
  function automatic logic [3:0] f_expect(bit rst, int m, bit sel, int s, bit ma, bit sa);
    bit to_s, to_m;
    if (!rst) return 4'b1110;
    to_s = f_srd(s) && sa && f_mwr(m, sel);
    to_m = f_mrd(m, sel) && ma && f_swr(s);
    return {!(f_mrd(m, sel) && !to_m), !(f_srd(s) && !to_s), !(to_s || to_m), to_s};
  endfunction

  task automatic drive(int m, bit sel, int s);
    mop = m; sop = s; msel_v = sel;
    m_sel    = sel;
    m_iorq_n = (m == 0);
    m_rd_n   = (m != 1);
    m_wr_n   = (m != 2);
    s_iorq_n = (s == 0);
    s_wr_n   = (s != 2);
  endtask

  task automatic step(int m, bit sel, int s, string tag);
    logic [3:0] exp_v, act_v;
    @(negedge clk);
    drive(m, sel, s);
    #3;
    exp_v = f_expect(rst_n, mop, msel_v, sop, m_arm, s_arm);
    act_v = {m_wait_n, s_wait_n, xcvr_oe_n, xcvr_dir};
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s: {m_wait_n,s_wait_n,oe_n,dir} actual=%b expected=%b", tag, act_v, exp_v);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_arm = 1'b0; s_arm = 1'b0;
    end else begin
      m_arm = f_mrd(mop, msel_v) && (m_arm || !f_swr(sop));
      s_arm = f_srd(sop) && (s_arm || !f_mwr(mop, msel_v));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int mh, sh, mcur, scur;
    bit scur_sel;
    void'($urandom(32'd4242));
    m_arm = 0; s_arm = 0;
    rst_n = 1'b0;
    drive(0, 1, 0);
    // R9: reset forces safe outputs even with both sides reading
    step(1, 1, 1, "R9 reset both reading");
    step(1, 1, 2, "R9 reset with slave write");
    rst_n = 1'b1;
    step(0, 1, 0, "R9 idle after reset");

    // R1 then R4 slave-to-master, R10 held open
    step(1, 1, 0, "R1 master waits");
    step(1, 1, 0, "R1 master still waits");
    step(1, 1, 2, "R4 slave write opens to master");
    step(1, 1, 2, "R10 transfer stays open");
    step(0, 1, 0, "R7 idle closes path");

    // R2 interrupt acknowledge waits, R4 master-to-slave
    step(0, 1, 3, "R2 slave iack waits");
    step(0, 1, 3, "R2 slave iack still waits");
    step(2, 1, 3, "R4 master vector write to slave");
    step(2, 1, 3, "R10 vector path held");
    step(0, 1, 0, "R7 idle");

    // R5 write already running when read appears
    step(2, 1, 0, "R3 master write alone");
    step(2, 1, 1, "R5 read after write start waits");
    step(2, 1, 1, "R5 stale write stays lost");
    step(0, 1, 1, "R2 slave keeps waiting");
    step(2, 1, 1, "R4 fresh write transfers");
    step(0, 1, 0, "R7 idle");

    // R5 simultaneous start
    step(1, 1, 2, "R5 same-cycle start lost");
    step(1, 1, 2, "R5 same-cycle still lost");
    step(0, 1, 0, "R7 idle");

    // R6 mutual read deadlock
    step(1, 1, 1, "R6 both read");
    step(1, 1, 1, "R6 both still wait");
    step(1, 1, 1, "R6 deadlock persists");
    step(2, 1, 1, "R4 master breaks deadlock");
    step(0, 1, 0, "R7 idle");

    // R8 deselected master
    step(1, 0, 0, "R8 deselected read no wait");
    step(0, 1, 1, "R2 slave arms");
    step(2, 0, 1, "R8 deselected write ignored");
    step(0, 1, 0, "R7 idle");
    step(0, 1, 2, "R3 slave write alone");

    // random held strobes
    mh = 0; sh = 0; mcur = 0; scur = 0; scur_sel = 1;
    for (int i = 0; i < 4000; i++) begin
      if (mh == 0) begin
        mcur = $urandom_range(0, 2);
        scur_sel = ($urandom_range(0, 7) != 0);
        mh = $urandom_range(1, 4);
      end
      if (sh == 0) begin
        scur = $urandom_range(0, 3);
        sh = $urandom_range(1, 4);
      end
      step(mcur, scur_sel, scur, "R1/R2/R3/R4/R5/R6/R7 random");
      mh--; sh--;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule